// File: doc/BRIEF.md
# Scanout Base Flip Controller

This block holds the control and status state of one display pipe. Its central job is a double-buffered scanout base address. Two base-address registers are held, and a hardware-owned flag selects which of them feeds scanout.

Software asks for a swap by writing a request bit. The swap then happens on the first cycle of the next vertical blank. A second request swaps back. The scanout base output is reloaded from the register in use only on that first vertical-blank cycle. Software may therefore rewrite the in-use register at any time without tearing the current frame.

The block also does the following:
- It stores the output-enable, gamma-enable and burst-step settings and drives them out.
- It returns the live scan position.
- It counts vertical blanks.
- It performs a soft reset of the pipe state when the active-low reset control bit is cleared from 1 to 0.

It runs in the pixel clock domain. It has a simple register bus with write strobe, word address, write data and combinational read data. Nothing at its edge carries flowing data, so every pin is plain control or status, with no valid/ready handshake.

Top module: `scanout_flip_ctrl`

## Requirements
- R1: After hard reset, address 0 (config) reads 0x0010_0000, the vblank count (address 4) reads 0, and `scan_base` is 0.
- R2: Writing config with bit 7 = 1 makes bit 7 read 1 (swap pending). On the first cycle of the next vertical blank (the rising edge of `tm_vblank`), the in-use flag (config bit 11) toggles and bit 7 returns to 0.
- R3: A swap request written while one is already pending is ignored, so at most one swap happens per vertical blank. A vertical blank with nothing pending leaves the in-use flag unchanged.
- R4: On the first vertical-blank cycle, `scan_base` loads the register selected by the in-use flag as it stands after that cycle's swap. `scan_base` changes at no other time, including during the rest of the vertical blank and during active video.
- R5: Address 1 holds base register 0 and address 2 holds base register 1. They read back their low BASE_W bits, and the upper bits read 0. A write to the register in use reaches `scan_base` at the next vertical blank, with no swap needed.
- R6: Config bit 11 is read-only. Writing 0 or 1 to it leaves the flag unchanged. Writing bit 7 = 0 requests nothing.
- R7: Config bit 8 is stored and drives `out_enable`. Config bit 12 is stored and drives `gamma_enable`.
- R8: Config bits [17:16] store the burst step. `burst_bytes` is 256, 128, 64 or 32 for the values 0, 1, 2 and 3.
- R9: Address 3 reads {`tm_x`, `tm_y`}, with X in bits [31:16] and Y in bits [15:0].
- R10: The vblank count at address 4 increases by one on every rising edge of `tm_vblank`. It wraps modulo 2^CNT_W.
- R11: A config write that changes bit 20 from 1 to 0 performs a soft reset. The soft reset clears the pending swap, the vblank count and the in-use flag, and pulses `soft_rst_pulse` for one cycle. The base registers and the stored config fields keep their values. Writing bit 20 as 0 when it is already 0, or writing it as 1, does not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address of register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tm_vblank | input | 1 | Vertical blank from timing |
| tm_x | input | 16 | Current scan X position |
| tm_y | input | 16 | Current scan Y position |
| scan_base | output | BASE_W | Scanout base address |
| out_enable | output | 1 | Pipe output enable |
| gamma_enable | output | 1 | Gamma enable |
| burst_bytes | output | 9 | Burst step in bytes |
| soft_rst_pulse | output | 1 | One-cycle soft reset indication |

## Verification
The bench builds the block with BASE_W = 24 and CNT_W = 4. The narrow base width lets one write show that address bits above the register width are dropped on readback. The 4-bit counter wraps after sixteen vertical blanks, so the wrap case is reached in a short run. The scoreboard queues the expected value for each register read and compares it against the read data just after the clock edge that settles it.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int REG_W = 32;
  localparam int POS_W = 16;

  // config bit positions
  localparam int FLIP_BIT  = 7;
  localparam int OEN_BIT   = 8;
  localparam int INUSE_BIT = 11;
  localparam int GAMMA_BIT = 12;
  localparam int STEP_LO   = 16;
  localparam int RSTN_BIT  = 20;

  typedef enum logic [2:0] {
    SEL_CFG  = 3'd0,
    SEL_FB0  = 3'd1,
    SEL_FB1  = 3'd2,
    SEL_POS  = 3'd3,
    SEL_VCNT = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic       out_en;
    logic       gamma_en;
    logic [1:0] step;
    logic       rst_ctl;
  } cfg_fields_t;

  function automatic logic [8:0] step_to_bytes(input logic [1:0] step);
    return 9'd256 >> step;
  endfunction

endpackage

// File: rtl/sfc_cfg_regs.sv
module sfc_cfg_regs
  import sfc_pkg::*;
#(
  parameter int BASE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_cfg,
  input  logic [1:0]              wr_fb,
  input  logic [REG_W-1:0]        wdata,
  output cfg_fields_t             cfg,
  output logic [1:0][BASE_W-1:0]  fb_q,
  output logic                    soft_rst_now
);

  // falling edge of the stored reset-control bit, caused by a write
  assign soft_rst_now = wr_cfg & cfg.rst_ctl & ~wdata[RSTN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.out_en   <= 1'b0;
      cfg.gamma_en <= 1'b0;
      cfg.step     <= 2'd0;
      cfg.rst_ctl  <= 1'b1;
    end else if (wr_cfg) begin
      cfg.out_en   <= wdata[OEN_BIT];
      cfg.gamma_en <= wdata[GAMMA_BIT];
      cfg.step     <= wdata[STEP_LO +: 2];
      cfg.rst_ctl  <= wdata[RSTN_BIT];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_fb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fb_q[g] <= '0;
      else if (wr_fb[g])
        fb_q[g] <= wdata[BASE_W-1:0];
    end
  end

endmodule

// File: rtl/sfc_flip_engine.sv
module sfc_flip_engine #(
  parameter int BASE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tm_vblank,
  input  logic                    flip_req,
  input  logic                    soft_rst,
  input  logic [1:0][BASE_W-1:0]  fb_q,
  output logic                    vb_start,
  output logic                    in_use,
  output logic                    flip_pend,
  output logic [BASE_W-1:0]       scan_base
);

  logic vb_d;
  logic swap_now;
  logic in_use_nx;
  logic pend_nx;

  assign vb_start = tm_vblank & ~vb_d;
  assign swap_now = vb_start & flip_pend;

  always_comb begin
    if (soft_rst) begin
      in_use_nx = 1'b0;
      pend_nx   = 1'b0;
    end else if (swap_now) begin
      in_use_nx = ~in_use;
      pend_nx   = 1'b0;     // a request in this cycle is dropped
    end else begin
      in_use_nx = in_use;
      pend_nx   = flip_pend | flip_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_d      <= 1'b0;
      in_use    <= 1'b0;
      flip_pend <= 1'b0;
      scan_base <= '0;
    end else begin
      vb_d      <= tm_vblank;
      in_use    <= in_use_nx;
      flip_pend <= pend_nx;
      if (vb_start)
        scan_base <= fb_q[in_use_nx];
    end
  end

endmodule

// File: rtl/sfc_vblank_counter.sv
module sfc_vblank_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vb_start,
  input  logic             soft_rst,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (soft_rst)
      count <= '0;
    else if (vb_start)
      count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/scanout_flip_ctrl.sv
module scanout_flip_ctrl
  import sfc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BASE_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               tm_vblank,
  input  logic [POS_W-1:0]   tm_x,
  input  logic [POS_W-1:0]   tm_y,
  output logic [BASE_W-1:0]  scan_base,
  output logic               out_enable,
  output logic               gamma_enable,
  output logic [8:0]         burst_bytes,
  output logic               soft_rst_pulse
);

  localparam int SEL_W = 3;

  cfg_fields_t               cfg;
  logic [1:0][BASE_W-1:0]    fb_q;
  logic                      soft_rst_now;
  logic                      vb_start;
  logic                      in_use;
  logic                      flip_pend;
  logic [CNT_W-1:0]          vsync_count;
  logic                      hit;
  reg_sel_e                  sel;
  logic                      wr_cfg;
  logic [1:0]                wr_fb;

  assign hit    = (reg_addr >> SEL_W) == '0;
  assign sel    = reg_sel_e'(reg_addr[SEL_W-1:0]);
  assign wr_cfg = reg_we & hit & (sel == SEL_CFG);
  assign wr_fb  = {reg_we & hit & (sel == SEL_FB1),
                   reg_we & hit & (sel == SEL_FB0)};

  sfc_cfg_regs #(.BASE_W(BASE_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_cfg       (wr_cfg),
    .wr_fb        (wr_fb),
    .wdata        (reg_wdata),
    .cfg          (cfg),
    .fb_q         (fb_q),
    .soft_rst_now (soft_rst_now)
  );

  sfc_flip_engine #(.BASE_W(BASE_W)) u_flip (
    .clk       (clk),
    .rst_n     (rst_n),
    .tm_vblank (tm_vblank),
    .flip_req  (wr_cfg & reg_wdata[FLIP_BIT]),
    .soft_rst  (soft_rst_now),
    .fb_q      (fb_q),
    .vb_start  (vb_start),
    .in_use    (in_use),
    .flip_pend (flip_pend),
    .scan_base (scan_base)
  );

  sfc_vblank_counter #(.CNT_W(CNT_W)) u_vcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .vb_start (vb_start),
    .soft_rst (soft_rst_now),
    .count    (vsync_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      soft_rst_pulse <= 1'b0;
    else
      soft_rst_pulse <= soft_rst_now;
  end

  assign out_enable   = cfg.out_en;
  assign gamma_enable = cfg.gamma_en;
  assign burst_bytes  = step_to_bytes(cfg.step);

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      unique case (sel)
        SEL_CFG: begin
          reg_rdata[FLIP_BIT]       = flip_pend;
          reg_rdata[OEN_BIT]        = cfg.out_en;
          reg_rdata[INUSE_BIT]      = in_use;
          reg_rdata[GAMMA_BIT]      = cfg.gamma_en;
          reg_rdata[STEP_LO +: 2]   = cfg.step;
          reg_rdata[RSTN_BIT]       = cfg.rst_ctl;
        end
        SEL_FB0:  reg_rdata[BASE_W-1:0] = fb_q[0];
        SEL_FB1:  reg_rdata[BASE_W-1:0] = fb_q[1];
        SEL_POS:  reg_rdata = {tm_x, tm_y};
        SEL_VCNT: reg_rdata[CNT_W-1:0] = vsync_count;
        default:  reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int BASE_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tm_vblank,
  input logic [BASE_W-1:0] scan_base,
  input logic              in_use,
  input logic              flip_pend,
  input logic [CNT_W-1:0]  vsync_count,
  input logic              soft_rst_now
);

  logic vb_q;
  logic vb_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vb_q <= 1'b0;
    else        vb_q <= tm_vblank;
  end
  assign vb_rise = tm_vblank & ~vb_q;

  p_flip_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_rise && flip_pend && !soft_rst_now) |=> (in_use != $past(in_use)) && !flip_pend);

  p_one_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(vb_rise && flip_pend) && !soft_rst_now) |=> $stable(in_use));

  p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vb_rise |=> $stable(scan_base));

  p_vcount_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_rise && !soft_rst_now) |=> vsync_count == $past(vsync_count) + CNT_W'(1));

  p_soft_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_now |=> (vsync_count == '0) && !in_use && !flip_pend);

endmodule

bind scanout_flip_ctrl sfc_checker #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tm_vblank    (tm_vblank),
  .scan_base    (scan_base),
  .in_use       (in_use),
  .flip_pend    (flip_pend),
  .vsync_count  (vsync_count),
  .soft_rst_now (soft_rst_now)
);

// File: tb/scanout_flip_ctrl_test.sv
`timescale 1ns/1ps
module scanout_flip_ctrl_test;

  localparam int ADDR_W = 3;
  localparam int BASE_W = 24;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              tm_vblank = 1'b0;
  logic [15:0]       tm_x = '0;
  logic [15:0]       tm_y = '0;
  logic [BASE_W-1:0] scan_base;
  logic              out_enable;
  logic              gamma_enable;
  logic [8:0]        burst_bytes;
  logic              soft_rst_pulse;

  int checks = 0;
  int failures = 0;
  int exp_vc = 0;
  logic mon_go = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  scanout_flip_ctrl #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tm_vblank(tm_vblank),
    .tm_x(tm_x), .tm_y(tm_y), .scan_base(scan_base), .out_enable(out_enable),
    .gamma_enable(gamma_enable), .burst_bytes(burst_bytes),
    .soft_rst_pulse(soft_rst_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value just after the edge
  always begin
    @(posedge clk);
    #5;
    if (mon_go) begin
      if (exp_q.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    mon_go = 1'b1;
    @(posedge clk);
    #6;
    mon_go = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #5;
    reg_we = 1'b0;
  endtask

  task automatic vb_rise();
    @(negedge clk);
    tm_vblank = 1'b1;
    @(posedge clk);
    #5;
    exp_vc++;
  endtask

  task automatic vb_fall();
    @(negedge clk);
    tm_vblank = 1'b0;
    @(posedge clk);
    #5;
  endtask

  task automatic vb_pulse();
    vb_rise();
    repeat (2) @(posedge clk);
    #5;
    vb_fall();
    repeat (2) @(posedge clk);
    #5;
  endtask

  function automatic logic [31:0] vc();
    return 32'(exp_vc % 16);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 scan_base", 32'(scan_base), 32'h0);
    rd(3'd0, 32'h0010_0000, "R1 config reset");
    rd(3'd4, 32'h0, "R1 vcount reset");

    wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h0000_2000);
    rd(3'd1, 32'h0000_1000, "R5 fb0 readback");
    rd(3'd2, 32'h0000_2000, "R5 fb1 readback");
    wr(3'd1, 32'hAB12_3456);
    rd(3'd1, 32'h0012_3456, "R5 fb0 upper bits dropped");
    wr(3'd1, 32'h0000_1000);
    chk("R4 no load before vblank", 32'(scan_base), 32'h0);

    vb_pulse();
    chk("R4 load fb0", 32'(scan_base), 32'h1000);
    rd(3'd4, vc(), "R10 count 1");
    rd(3'd0, 32'h0010_0000, "R3 no swap without request");

    wr(3'd0, 32'h0012_1180);
    rd(3'd0, 32'h0012_1180, "R2 pending visible");
    chk("R7 out_enable", 32'(out_enable), 32'd1);
    chk("R7 gamma_enable", 32'(gamma_enable), 32'd1);
    chk("R8 step 2", 32'(burst_bytes), 32'd64);
    chk("R4 hold while pending", 32'(scan_base), 32'h1000);

    wr(3'd0, 32'h0012_1180);
    vb_pulse();
    rd(3'd0, 32'h0012_1900, "R2 swapped and cleared");
    chk("R4 load fb1", 32'(scan_base), 32'h2000);
    vb_pulse();
    rd(3'd0, 32'h0012_1900, "R3 second request ignored");
    chk("R3 base after extra vblank", 32'(scan_base), 32'h2000);

    wr(3'd0, 32'h0012_1100);
    rd(3'd0, 32'h0012_1900, "R6 write 0 to in-use bit");
    wr(3'd0, 32'h0012_1000);
    chk("R7 out_enable off", 32'(out_enable), 32'd0);

    wr(3'd2, 32'h0000_3000);
    chk("R5 in-use write waits", 32'(scan_base), 32'h2000);
    vb_rise();
    chk("R5 in-use write loads", 32'(scan_base), 32'h3000);
    wr(3'd2, 32'h0000_4000);
    chk("R4 no load mid vblank", 32'(scan_base), 32'h3000);
    vb_fall();
    repeat (3) @(posedge clk);
    #5;
    chk("R4 no load in active video", 32'(scan_base), 32'h3000);
    vb_pulse();
    chk("R4 next vblank loads", 32'(scan_base), 32'h4000);
    rd(3'd4, vc(), "R10 count after five");

    @(negedge clk);
    tm_x = 16'h0123; tm_y = 16'h0456;
    rd(3'd3, 32'h0123_0456, "R9 scan position");
    @(negedge clk);
    tm_x = 16'hFFFE; tm_y = 16'h0001;
    rd(3'd3, 32'hFFFE_0001, "R9 scan position 2");

    wr(3'd0, 32'h0013_1980);
    chk("R8 step 3", 32'(burst_bytes), 32'd32);
    rd(3'd0, 32'h0013_1980, "R6 in-use ignores write 1");
    wr(3'd0, 32'h0003_1100);
    chk("R11 pulse", 32'(soft_rst_pulse), 32'd1);
    exp_vc = 0;
    rd(3'd0, 32'h0003_1100, "R11 config after soft reset");
    chk("R11 pulse one cycle", 32'(soft_rst_pulse), 32'd0);
    rd(3'd4, 32'h0, "R11 count cleared");
    rd(3'd2, 32'h0000_4000, "R11 fb1 retained");
    vb_pulse();
    chk("R11 in-use back to fb0", 32'(scan_base), 32'h1000);
    rd(3'd0, 32'h0003_1100, "R11 no pending after reset");

    wr(3'd0, 32'h0000_0100);
    chk("R11 no pulse when already 0", 32'(soft_rst_pulse), 32'd0);
    chk("R8 step 0", 32'(burst_bytes), 32'd256);
    wr(3'd0, 32'h0001_0100);
    chk("R8 step 1", 32'(burst_bytes), 32'd128);
    wr(3'd0, 32'h0010_0000);
    chk("R11 no pulse on rise", 32'(soft_rst_pulse), 32'd0);
    rd(3'd4, vc(), "R11 count kept");

    for (int i = 0; i < 16; i++) vb_pulse();
    rd(3'd4, vc(), "R10 wrap");
    vb_pulse();
    rd(3'd4, vc(), "R10 after wrap");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule